// File: doc/BRIEF.md
# Page Table Walk Assist Unit

This unit performs the two table-read steps that software or a refill sequencer uses to walk a multi-level page table after a translation miss. A directory step takes a table base, a level number and the faulting virtual address. It extracts that level's index field from the address, reads one 64-bit word from physical memory and returns the base of the next level down. A directory step can also meet a huge-page entry partway through the walk. It then tags that entry with its level instead of reading memory.

A leaf step takes either a last-level table base or a huge-page entry, plus an even/odd select. It produces one half of a paired translation entry and writes it to the even or the odd result register, and it updates a page-size output. The bit position and width of each level's index field come from packed configuration inputs. Slot 0 holds the last-level (PTE) field and slots 1 to 4 hold directory levels 1 to 4. Operations start with a one-cycle `start_i` pulse. The memory port issues a one-cycle request and waits any number of cycles for the matching `mem_rvalid_i`.

Top module: `pwh_walk_assist`

## Requirements
- R1: A directory step (`op_i`=0) whose `level_i` is 0 or greater than 4 returns `base_i` unchanged in `dir_result_o`, and issues no memory request.
- R2: A directory step at level 4 whose `base_i` has bit 6 (huge marker) set returns `base_i` unchanged, and issues no memory request.
- R3: A directory step at level 1, 2 or 3 with bit 6 set issues no memory request. It returns `base_i` unchanged if bits 14:13 (level tag) are nonzero. Otherwise it returns `base_i` with bits 14:13 set to the low two bits of `level_i`.
- R4: A directory step at level 1 to 4 on a non-huge base reads from address (base & PA mask) | (index << 3). Here index = (fault address >> pos) & ((1 << width) − 1), using that level's configuration slot. `dir_result_o` becomes the read data ANDed with the PA mask, which keeps the low `PA_BITS` bits.
- R5: A leaf step (`op_i`=1) on a base whose bit 6 is clear works as follows. It takes the slot-0 index and clears the index's bit 0. It reads at masked base | (index << 3) for the even half, or at masked base | ((index + 1) << 3) for the odd half. It stores the read data ANDed with the PA mask, and sets `page_size_o` to the slot-0 position.
- R6: A leaf step on a masked base with bit 6 set builds its entry in three stages. It starts from the masked base and clears bits 14:13 and bit 6. If bit 12 (huge-global) is set, it then clears bit 12 and sets bit 6 (global).
- R7: For a huge leaf step, `page_size_o` is pos + width − 1 of the slot named by the entry's bits 14:13 (0 selects the slot-0 PTE field). The odd half adds (1 << page size) to the entry. No memory request is issued.
- R8: A leaf step writes `lo_odd_o` when `odd_i`=1 and `lo_even_o` otherwise. The other result register and `dir_result_o` are left unchanged, and `page_size_o` is updated on every leaf step.
- R9: `start_i` is accepted only while `busy_o` is low. `busy_o` stays high while a read is outstanding. `mem_req_o` is a one-cycle pulse. `done_o` is a one-cycle pulse that comes with the updated result, and it comes one cycle after `start_i` when no read is needed.
- R10: Reset clears all result registers, `page_size_o`, `busy_o`, `done_o` and `mem_req_o` to zero. Outside a completing step, every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_i | input | 1 | 0 = directory step, 1 = leaf step |
| level_i | input | 3 | Walk level for a directory step |
| odd_i | input | 1 | Leaf half select, 1 = odd |
| base_i | input | 64 | Table base or huge-page entry |
| fault_va_i | input | 64 | Faulting virtual address |
| cfg_pos_i | input | 30 | Five 6-bit index positions, slot k at [6k+5:6k] |
| cfg_wid_i | input | 25 | Five 5-bit index widths, slot k at [5k+4:5k] |
| busy_o | output | 1 | Read outstanding |
| done_o | output | 1 | Step complete pulse |
| dir_result_o | output | 64 | Directory step result |
| lo_even_o | output | 64 | Even half entry |
| lo_odd_o | output | 64 | Odd half entry |
| page_size_o | output | 6 | Page size from last leaf step |
| mem_req_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | 64 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |

## Verification
The assertions take three things for granted about the unit's inputs. `mem_rvalid_i` arrives exactly once for each request, and never while idle. The configuration stays constant while a step is in flight. For every slot, position plus width stays inside the 64-bit address. The bench's memory model answers each request once, after a programmable delay, with data whose upper bits are set so that PA masking is visible. It holds one fixed configuration for the whole run, with every field well inside the address. A second `start_i` during a pending read is the only out-of-protocol stimulus, and it is there to check that the unit ignores it.

// File: rtl/pwh_pkg.sv
package pwh_pkg;
    localparam int DW        = 64;
    localparam int POS_W     = 6;
    localparam int WID_W     = 5;
    localparam int NSLOT     = 5;
    localparam int LVL_W     = 3;
    localparam int PS_W      = 6;
    localparam int HUGE_BIT  = 6;
    localparam int GLOB_BIT  = 6;
    localparam int HGLOB_BIT = 12;
    localparam int LVLF_LO   = 13;
    localparam int LVLF_W    = 2;
    localparam int ENT_SHIFT = 3;
    localparam int MAX_LVL   = NSLOT - 1;

    typedef enum logic {
        OP_DIR  = 1'b0,
        OP_LEAF = 1'b1
    } op_e;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [WID_W-1:0] wid;
    } fld_t;

    function automatic logic [DW-1:0] pa_mask(input int bits);
        if (bits >= DW) return '1;
        return (DW'(1) << bits) - DW'(1);
    endfunction

    function automatic logic [LVLF_W-1:0] lvl_tag(input logic [DW-1:0] ent);
        return ent[LVLF_LO +: LVLF_W];
    endfunction

    function automatic logic [DW-1:0] put_lvl_tag(input logic [DW-1:0] ent,
                                                  input logic [LVLF_W-1:0] tag);
        logic [DW-1:0] r;
        r = ent;
        r[LVLF_LO +: LVLF_W] = tag;
        return r;
    endfunction
endpackage

// File: rtl/pwh_cfg_sel.sv
module pwh_cfg_sel
    import pwh_pkg::*;
(
    input  logic [LVL_W-1:0]       sel,
    input  logic [NSLOT*POS_W-1:0] pos_all,
    input  logic [NSLOT*WID_W-1:0] wid_all,
    output fld_t                   fld
);
    fld_t slot [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign slot[k] = {pos_all[k*POS_W +: POS_W], wid_all[k*WID_W +: WID_W]};
    end

    // Slot 0 (PTE field) is the fallback for any level outside 1..MAX_LVL
    always_comb begin
        fld = slot[0];
        for (int k = 1; k < NSLOT; k++) begin
            if (sel == LVL_W'(k)) fld = slot[k];
        end
    end
endmodule

// File: rtl/pwh_idx_addr.sv
module pwh_idx_addr
    import pwh_pkg::*;
(
    input  logic [DW-1:0] va,
    input  logic [DW-1:0] tbl,
    input  fld_t          fld,
    input  logic          pair_mode,
    input  logic          odd,
    output logic [DW-1:0] addr
);
    logic [DW-1:0] raw;
    logic [DW-1:0] idx;

    always_comb begin
        raw = (va >> fld.pos) & ((DW'(1) << fld.wid) - DW'(1));
        idx = raw;
        if (pair_mode) begin
            idx[0] = 1'b0;
            if (odd) idx = idx + DW'(1);
        end
        addr = tbl | (idx << ENT_SHIFT);
    end
endmodule

// File: rtl/pwh_huge_leaf.sv
module pwh_huge_leaf
    import pwh_pkg::*;
(
    input  logic [DW-1:0]   entry,
    input  logic            odd,
    input  fld_t            fld,
    output logic [DW-1:0]   leaf_val,
    output logic [PS_W-1:0] ps
);
    logic [DW-1:0] e;

    always_comb begin
        ps = PS_W'(fld.pos) + PS_W'(fld.wid) - PS_W'(1);
        e = entry;
        e[LVLF_LO +: LVLF_W] = '0;
        e[HUGE_BIT] = 1'b0;
        if (e[HGLOB_BIT]) begin
            e[HGLOB_BIT] = 1'b0;
            e[GLOB_BIT]  = 1'b1;
        end
        leaf_val = odd ? (e + (DW'(1) << ps)) : e;
    end
endmodule

// File: rtl/pwh_walk_assist.sv
module pwh_walk_assist
    import pwh_pkg::*;
#(
    parameter int PA_BITS = 48
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   op_i,
    input  logic [LVL_W-1:0]       level_i,
    input  logic                   odd_i,
    input  logic [DW-1:0]          base_i,
    input  logic [DW-1:0]          fault_va_i,
    input  logic [NSLOT*POS_W-1:0] cfg_pos_i,
    input  logic [NSLOT*WID_W-1:0] cfg_wid_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [DW-1:0]          dir_result_o,
    output logic [DW-1:0]          lo_even_o,
    output logic [DW-1:0]          lo_odd_o,
    output logic [PS_W-1:0]        page_size_o,
    output logic                   mem_req_o,
    output logic [DW-1:0]          mem_addr_o,
    input  logic                   mem_rvalid_i,
    input  logic [DW-1:0]          mem_rdata_i
);
    localparam logic [DW-1:0] PA_MASK = pa_mask(PA_BITS);

    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e             state_q;
    op_e             op_q;
    logic            odd_q;
    logic            done_q;
    logic            req_q;
    logic [DW-1:0]   addr_q;
    logic [DW-1:0]   dir_q;
    logic [DW-1:0]   even_q;
    logic [DW-1:0]   oddr_q;
    logic [PS_W-1:0] ps_q;

    op_e             op_in;
    logic [DW-1:0]   base_m;
    logic            huge_dir;
    logic            huge_leaf;
    logic            lvl_bad;
    logic [LVL_W-1:0] sel_lvl;
    fld_t            fld;
    logic [DW-1:0]   rd_addr;
    logic [DW-1:0]   hl_val;
    logic [PS_W-1:0] hl_ps;
    logic [DW-1:0]   dir_imm_val;
    logic            need_rd;
    logic [DW-1:0]   rdata_m;

    assign op_in     = op_e'(op_i);
    assign base_m    = base_i & PA_MASK;
    assign huge_dir  = base_i[HUGE_BIT];
    assign huge_leaf = base_m[HUGE_BIT];
    assign lvl_bad   = (level_i == '0) || (level_i > LVL_W'(MAX_LVL));
    assign rdata_m   = mem_rdata_i & PA_MASK;

    // Leaf: huge entries pick the slot named by their own level tag, else slot 0
    always_comb begin
        if (op_in == OP_LEAF)
            sel_lvl = huge_leaf ? {{(LVL_W-LVLF_W){1'b0}}, lvl_tag(base_m)} : '0;
        else
            sel_lvl = level_i;
    end

    pwh_cfg_sel u_cfg (
        .sel     (sel_lvl),
        .pos_all (cfg_pos_i),
        .wid_all (cfg_wid_i),
        .fld     (fld)
    );

    pwh_idx_addr u_idx (
        .va        (fault_va_i),
        .tbl       (base_m),
        .fld       (fld),
        .pair_mode (op_in == OP_LEAF),
        .odd       (odd_i),
        .addr      (rd_addr)
    );

    pwh_huge_leaf u_huge (
        .entry    (base_m),
        .odd      (odd_i),
        .fld      (fld),
        .leaf_val (hl_val),
        .ps       (hl_ps)
    );

    // Directory step that finishes without a read
    always_comb begin
        if (lvl_bad || level_i == LVL_W'(MAX_LVL) || lvl_tag(base_i) != '0)
            dir_imm_val = base_i;
        else
            dir_imm_val = put_lvl_tag(base_i, level_i[LVLF_W-1:0]);
    end

    assign need_rd = (op_in == OP_DIR) ? !(lvl_bad || huge_dir) : !huge_leaf;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_DIR;
            odd_q   <= 1'b0;
            done_q  <= 1'b0;
            req_q   <= 1'b0;
            addr_q  <= '0;
            dir_q   <= '0;
            even_q  <= '0;
            oddr_q  <= '0;
            ps_q    <= '0;
        end else begin
            done_q <= 1'b0;
            req_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q  <= op_in;
                        odd_q <= odd_i;
                        if (need_rd) begin
                            req_q   <= 1'b1;
                            addr_q  <= rd_addr;
                            state_q <= ST_WAIT;
                        end else begin
                            done_q <= 1'b1;
                            if (op_in == OP_DIR) begin
                                dir_q <= dir_imm_val;
                            end else begin
                                if (odd_i) oddr_q <= hl_val;
                                else       even_q <= hl_val;
                                ps_q <= hl_ps;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid_i) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                        if (op_q == OP_DIR) begin
                            dir_q <= rdata_m;
                        end else begin
                            if (odd_q) oddr_q <= rdata_m;
                            else       even_q <= rdata_m;
                            ps_q <= PS_W'(cfg_pos_i[POS_W-1:0]);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign mem_req_o    = req_q;
    assign mem_addr_o   = addr_q;
    assign dir_result_o = dir_q;
    assign lo_even_o    = even_q;
    assign lo_odd_o     = oddr_q;
    assign page_size_o  = ps_q;

    AST_BAD_LEVEL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q == ST_IDLE && op_i == 1'b0 && (level_i == 3'd0 || level_i > 3'd4))
        |=> (!mem_req_o && done_o && dir_result_o == $past(base_i))); // R1

    AST_HUGE_TOP_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q == ST_IDLE && op_i == 1'b0 && level_i == 3'd4 && base_i[HUGE_BIT])
        |=> (!mem_req_o && dir_result_o == $past(base_i))); // R2

    AST_DIR_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && mem_rvalid_i && op_q == OP_DIR)
        |=> ((dir_result_o & ~PA_MASK) == '0)); // R4

    AST_HUGE_LEAF_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q == ST_IDLE && op_i == 1'b1 && base_m[HUGE_BIT])
        |=> (!mem_req_o && done_o)); // R7

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start_i)
        |=> ($stable(dir_result_o) && $stable(lo_even_o) && $stable(lo_odd_o)
             && $stable(page_size_o))); // R10
endmodule

// File: tb/sim_pwh_walk_assist.sv
`timescale 1ns/1ps
module sim_pwh_walk_assist;
    localparam logic [63:0] PAM = (64'd1 << 48) - 64'd1;
    localparam int CPOS [5] = '{12, 21, 30, 39, 48};
    localparam int CWID [5] = '{9, 9, 9, 9, 9};
    localparam logic [63:0] VA0 = 64'h0000_7F3A_C5D2_E468;
    localparam logic [63:0] VA1 = 64'h0000_1234_89AB_CDEF;

    typedef struct packed {
        logic        op;
        logic [2:0]  lvl;
        logic        odd;
        logic [63:0] base;
        logic [63:0] va;
        logic [3:0]  lat;
        logic [3:0]  rq;
    } vec_t;

    typedef struct packed {
        logic        rd;
        logic [63:0] addr;
        logic [63:0] res;
        logic [5:0]  ps;
    } exp_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd1, 1'b0, 64'h0000_0000_0010_0000, VA0, 4'd1, 4'd4},  // R4
        '{1'b0, 3'd2, 1'b0, 64'hFFFF_0000_0020_0000, VA1, 4'd3, 4'd4},  // R4 base masking
        '{1'b0, 3'd3, 1'b0, 64'h0000_0000_0030_0000, VA0, 4'd0, 4'd4},  // R4
        '{1'b0, 3'd4, 1'b0, 64'h0000_0000_0050_0000, VA1, 4'd5, 4'd4},  // R4
        '{1'b0, 3'd0, 1'b0, 64'hDEAD_0000_0060_0000, VA0, 4'd1, 4'd1},  // R1
        '{1'b0, 3'd5, 1'b0, 64'hBEEF_0000_0070_0040, VA0, 4'd1, 4'd1},  // R1
        '{1'b0, 3'd4, 1'b0, 64'h0000_0000_9000_0040, VA0, 4'd1, 4'd2},  // R2
        '{1'b0, 3'd2, 1'b0, 64'h0000_0000_8000_0040, VA0, 4'd1, 4'd3},  // R3 tag written
        '{1'b0, 3'd3, 1'b0, 64'h0000_0000_8000_2040, VA0, 4'd1, 4'd3},  // R3 tag kept
        '{1'b1, 3'd0, 1'b0, 64'h0000_0000_0040_0000, VA0, 4'd2, 4'd5},  // R5 even
        '{1'b1, 3'd0, 1'b1, 64'hABCD_0000_0040_0000, VA0, 4'd4, 4'd5},  // R5 odd
        '{1'b1, 3'd0, 1'b0, 64'h0000_0000_4000_2040, VA0, 4'd1, 4'd6},  // R6 plain
        '{1'b1, 3'd0, 1'b1, 64'h0000_0000_8000_5040, VA0, 4'd1, 4'd6},  // R6 huge-global
        '{1'b1, 3'd0, 1'b0, 64'hFFFF_0000_0100_0040, VA0, 4'd1, 4'd7},  // R7 tag 0
        '{1'b1, 3'd0, 1'b1, 64'h0000_0001_0000_6040, VA0, 4'd1, 4'd7}   // R7 tag 3 odd
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [2:0]  level_i = '0;
    logic        odd_i = 1'b0;
    logic [63:0] base_i = '0;
    logic [63:0] fault_va_i = '0;
    logic [29:0] cfg_pos_i;
    logic [24:0] cfg_wid_i;
    logic        busy_o, done_o, mem_req_o;
    logic [63:0] dir_result_o, lo_even_o, lo_odd_o, mem_addr_o;
    logic [5:0]  page_size_o;
    logic        mem_rvalid_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int req_cnt = 0;
    logic [63:0] last_addr = '0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [63:0] paddr = '0;

    assign cfg_pos_i = {6'd48, 6'd39, 6'd30, 6'd21, 6'd12};
    assign cfg_wid_i = {5'd9, 5'd9, 5'd9, 5'd9, 5'd9};

    always #2.5 clk = ~clk;

    pwh_walk_assist u0 (
        .clk, .rst, .start_i, .op_i, .level_i, .odd_i, .base_i, .fault_va_i,
        .cfg_pos_i, .cfg_wid_i, .busy_o, .done_o, .dir_result_o, .lo_even_o,
        .lo_odd_o, .page_size_o, .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i
    );

    function automatic logic [63:0] mdata(input logic [63:0] a);
        return {~a[31:0], a[31:0] ^ 32'h0F0F_1234};
    endfunction

    // Memory model: one answer per request after a programmable delay
    always @(posedge clk) begin
        mem_rvalid_i <= 1'b0;
        if (mem_req_o) begin
            pend      <= 1'b1;
            cnt       <= lat;
            paddr     <= mem_addr_o;
            req_cnt   <= req_cnt + 1;
            last_addr <= mem_addr_o;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rvalid_i <= 1'b1;
                mem_rdata_i  <= mdata(paddr);
                pend         <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    function automatic exp_t model(input logic op, input logic [2:0] lvl, input logic odd,
                                   input logic [63:0] base, input logic [63:0] va);
        exp_t e;
        logic [63:0] mb, ent, idx;
        int p, w, s;
        e  = '0;
        mb = base & PAM;
        if (!op) begin
            if (lvl == 0 || lvl > 4) begin
                e.res = base;
            end else if (base[6]) begin
                e.res = base;
                if (lvl != 4 && base[14:13] == 2'd0) e.res[14:13] = lvl[1:0];
            end else begin
                p = CPOS[lvl]; w = CWID[lvl];
                idx = (va >> p) & ((64'd1 << w) - 64'd1);
                e.addr = mb | (idx << 3);
                e.rd = 1'b1;
                e.res = mdata(e.addr) & PAM;
            end
        end else if (mb[6]) begin
            s = int'(mb[14:13]);
            p = CPOS[s]; w = CWID[s];
            e.ps = 6'(p + w - 1);
            ent = mb;
            ent[14:13] = 2'd0;
            ent[6] = 1'b0;
            if (ent[12]) begin
                ent[12] = 1'b0;
                ent[6]  = 1'b1;
            end
            e.res = odd ? ent + (64'd1 << e.ps) : ent;
        end else begin
            idx = ((va >> CPOS[0]) & ((64'd1 << CWID[0]) - 64'd1)) & ~64'd1;
            if (odd) idx = idx + 64'd1;
            e.addr = mb | (idx << 3);
            e.rd = 1'b1;
            e.res = mdata(e.addr) & PAM;
            e.ps = 6'(CPOS[0]);
        end
        return e;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done_o && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        if (!done_o) chk("R9", "done never seen", 64'd0, 64'd1);
    endtask

    task automatic launch(input logic op, input logic [2:0] lvl, input logic odd,
                          input logic [63:0] base, input logic [63:0] va, input int l);
        @(negedge clk);
        op_i = op; level_i = lvl; odd_i = odd; base_i = base; fault_va_i = va;
        lat = l; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        exp_t e;
        string tag;
        logic [63:0] pe, po, pd;
        logic [5:0] pps;
        int rc0;
        tag = $sformatf("R%0d", v.rq);
        pe = lo_even_o; po = lo_odd_o; pd = dir_result_o; pps = page_size_o;
        rc0 = req_cnt;
        e = model(v.op, v.lvl, v.odd, v.base, v.va);
        launch(v.op, v.lvl, v.odd, v.base, v.va, int'(v.lat));
        wait_done();
        chk(tag, "memory reads", 64'(req_cnt - rc0), 64'(e.rd));
        if (e.rd) chk(tag, "read address", last_addr, e.addr);
        if (!v.op) begin
            chk(tag, "dir_result", dir_result_o, e.res);
            chk(tag, "page size kept on dir step", 64'(page_size_o), 64'(pps));
        end else begin
            chk(tag, "leaf result", v.odd ? lo_odd_o : lo_even_o, e.res);
            chk("R8", "other half kept", v.odd ? lo_even_o : lo_odd_o, v.odd ? pe : po);
            chk("R8", "dir_result kept", dir_result_o, pd);
            chk("R8", "page size", 64'(page_size_o), 64'(e.ps));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_t e1;
        int rc0;
        logic [63:0] se, so, sd;
        logic [5:0] sp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "reset dir_result", dir_result_o, 64'd0);
        chk("R10", "reset even", lo_even_o, 64'd0);
        chk("R10", "reset odd", lo_odd_o, 64'd0);
        chk("R10", "reset ctrl", {58'd0, page_size_o}, 64'd0);
        chk("R10", "reset flags", {61'd0, busy_o, done_o, mem_req_o}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: immediate step finishes one cycle after start; done is a pulse
        launch(1'b0, 3'd0, 1'b0, 64'h1111_2222_3333_4444, VA0, 1);
        chk("R9", "done one cycle after start", 64'(done_o), 64'd1);
        @(negedge clk);
        chk("R9", "done pulse ends", 64'(done_o), 64'd0);

        // R9: start ignored while busy
        rc0 = req_cnt;
        e1 = model(1'b0, 3'd1, 1'b0, 64'h0000_0000_00A0_0000, VA1);
        launch(1'b0, 3'd1, 1'b0, 64'h0000_0000_00A0_0000, VA1, 8);
        @(negedge clk);
        chk("R9", "busy while read pending", 64'(busy_o), 64'd1);
        op_i = 1'b0; level_i = 3'd0; base_i = 64'h5555_5555_5555_5555; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk("R9", "busy low at done", 64'(busy_o), 64'd0);
        chk("R9", "result of first step", dir_result_o, e1.res);
        chk("R9", "single request", 64'(req_cnt - rc0), 64'd1);
        @(negedge clk);
        chk("R9", "no second completion", 64'(done_o), 64'd0);

        // R10: outputs hold while idle with inputs moving
        se = lo_even_o; so = lo_odd_o; sd = dir_result_o; sp = page_size_o;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            base_i = base_i + 64'h1000; odd_i = ~odd_i; op_i = ~op_i;
        end
        chk("R10", "hold dir", dir_result_o, sd);
        chk("R10", "hold even", lo_even_o, se);
        chk("R10", "hold odd", lo_odd_o, so);
        chk("R10", "hold ps", 64'(page_size_o), 64'(sp));

        // R10: reset clears results again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "reset clears results", dir_result_o | lo_even_o | lo_odd_o, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule